// File: doc/BRIEF.md
# Interrupt Pin Redirection Controller

This block watches a set of interrupt input pins and turns each qualifying pin event into an interrupt message. Every pin has a two-word redirection entry. The low word holds the vector, the delivery mode, the destination addressing mode, the input polarity, the trigger mode and a mask bit. The high word holds the destination ID. A pin in edge mode produces one message for each transition into its active level. A pin in level mode produces a message while it is active. In level mode the accepted message sets a remote-pending flag, and further messages wait until that flag clears.

Software reaches every register through a two-location indirect window. It writes a select value at offset 0x00, then reads or writes the chosen register at offset 0x10. Select 0x00 is the controller ID. Select 0x01 reports the table size. The entries start at select 0x10. Messages leave on a valid/ready output. An end-of-interrupt input carries a vector and releases every level entry waiting on that vector.

Top module: `irq_redirect_unit`

## Requirements
- R1: A write at offset 0x00 loads the select register from data bits 7:0. A read at offset 0x00 returns the select value in bits 7:0 and zero in all other bits. Reads are combinational. Offset 0x10 reads or writes the register named by the select value.
- R2: Select 0x00 is the ID register. Only bits 27:24 are stored. All other bits read as zero.
- R3: Select 0x01 is read-only. It returns the entry count minus one in bits 23:16 and the code 0x11 in bits 7:0. All other bits read as zero.
- R4: Entry n has its low word at select 0x10+2n and its high word at 0x11+2n. The low word holds vector 7:0, delivery mode 10:8, logical destination 11, delivery status 12, active-low polarity 13, remote pending 14, level trigger 15 and mask 16. The high word holds the destination in bits 31:24. Writes to bits 12 and 14 are ignored. Unlisted bits, and selects beyond the table, read as zero.
- R5: After reset every entry reads 0x00010000 (masked, edge, active high), its high word reads zero, the ID is zero and no message is offered.
- R6: Each pin passes through one sampling register. A pin is active when its sampled level differs from the polarity bit. An active-low entry ignores a rising pin and fires on a falling pin.
- R7: An unmasked edge entry offers exactly one message per inactive-to-active transition. msg_valid rises after the second rising clock edge that follows the pin change.
- R8: An unmasked level entry offers a message while it is active and remote pending is clear. msg_valid rises after the first clock edge that follows the pin change. Acceptance sets remote pending, and the entry then stays silent.
- R9: An end-of-interrupt with a vector clears remote pending, at the next clock edge, in every level entry whose vector equals it. A non-matching vector changes nothing.
- R10: An entry in edge mode holds remote pending at zero. Rewriting a stuck level entry as masked edge and then as unmasked level therefore leaves remote pending clear, and delivery resumes.
- R11: A masked entry offers nothing. Edges seen while masked are lost. Masking an entry drops an edge request it has already latched.
- R12: The message carries the winning entry's vector, delivery mode, destination mode, trigger mode and destination. The lowest-numbered requesting entry wins. A request stays offered until msg_ready accepts it. Delivery status reads 1 while the entry has an unaccepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_off | input | 8 | Register access offset (0x00 select, 0x10 window) |
| acc_we | input | 1 | Write strobe for the access port |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Combinational read data |
| irq_pins | input | NPIN | Interrupt input pins |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Interrupt message offered |
| msg_ready | input | 1 | Message accepted when high together with msg_valid |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Destination is a logical ID |
| msg_level | output | 1 | Message comes from a level-triggered entry |
| msg_dest | output | 8 | Destination ID |

## Verification
Register reads are combinational, so the bench samples them in the same cycle the select is in place. A register write takes effect at the next clock edge. An edge-mode pin change reaches msg_valid after two clock edges and a level-mode change after one. An end-of-interrupt acts at the following edge. A behavioural model advances on each rising edge, and its message prediction is compared with the outputs at every falling edge, so each latency is checked to the exact cycle. Explicit checks after a pin change also count those edges and sample msg_valid before and at the cycle it is due. Register contents and delivery counts are read at falling edges once the stated number of edges has passed.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam logic [7:0] OFF_INDEX  = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;

  localparam logic [7:0] SEL_ID   = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_TBL  = 8'h10;
  localparam logic [7:0] VER_CODE = 8'h11;

  localparam int LO_DSTAT = 12;
  localparam int LO_POL   = 13;
  localparam int LO_RPEND = 14;
  localparam int LO_TRIG  = 15;
  localparam int LO_MASK  = 16;

  typedef struct packed {
    logic       mask;
    logic       lvl;
    logic       act_low;
    logic       dst_logical;
    logic [2:0] dmode;
    logic [7:0] vec;
    logic [7:0] dest;
  } redir_cfg_t;

  function automatic redir_cfg_t cfg_reset();
    redir_cfg_t c;
    c      = '0;
    c.mask = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int NPIN = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              acc_off,
  input  logic                    acc_we,
  input  logic [31:0]             acc_wdata,
  output logic [31:0]             acc_rdata,
  input  logic [NPIN-1:0]         rpend_i,
  input  logic [NPIN-1:0]         busy_i,
  output redir_cfg_t [NPIN-1:0]   cfg_o
);

  localparam int TBL_FIRST = int'(SEL_TBL);
  localparam int TBL_LAST  = TBL_FIRST + 2 * NPIN - 1;

  logic [7:0]            sel_q, sel_d;
  logic [3:0]            cid_q, cid_d;
  redir_cfg_t [NPIN-1:0] cfg_q, cfg_d;

  logic       sel_wr, win_wr, tbl_hit, cid_en, cfg_en, hi_half;
  logic [7:0] rel;
  logic [6:0] ent;
  logic       unused_wbits;

  assign sel_wr  = acc_we && (acc_off == OFF_INDEX);
  assign win_wr  = acc_we && (acc_off == OFF_WINDOW);
  assign tbl_hit = (int'(sel_q) >= TBL_FIRST) && (int'(sel_q) <= TBL_LAST);
  assign rel     = sel_q - SEL_TBL;
  assign ent     = rel[7:1];
  assign hi_half = rel[0];
  assign cid_en  = win_wr && (sel_q == SEL_ID);
  assign cfg_en  = win_wr && tbl_hit;
  assign unused_wbits = ^{acc_wdata[23:17], acc_wdata[LO_RPEND], acc_wdata[LO_DSTAT]};

  // next state
  always_comb begin
    sel_d = acc_wdata[7:0];
    cid_d = acc_wdata[27:24];
    for (int i = 0; i < NPIN; i++) begin
      cfg_d[i] = cfg_q[i];
      if (int'(ent) == i) begin
        if (hi_half) begin
          cfg_d[i].dest = acc_wdata[31:24];
        end else begin
          cfg_d[i].vec         = acc_wdata[7:0];
          cfg_d[i].dmode       = acc_wdata[10:8];
          cfg_d[i].dst_logical = acc_wdata[11];
          cfg_d[i].act_low     = acc_wdata[LO_POL];
          cfg_d[i].lvl         = acc_wdata[LO_TRIG];
          cfg_d[i].mask        = acc_wdata[LO_MASK];
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cid_q <= '0;
      for (int i = 0; i < NPIN; i++) cfg_q[i] <= cfg_reset();
    end else begin
      if (sel_wr) sel_q <= sel_d;
      if (cid_en) cid_q <= cid_d;
      if (cfg_en) cfg_q <= cfg_d;
    end
  end

  // read path
  always_comb begin
    acc_rdata = '0;
    if (acc_off == OFF_INDEX) begin
      acc_rdata[7:0] = sel_q;
    end else if (acc_off == OFF_WINDOW) begin
      if (sel_q == SEL_ID) begin
        acc_rdata[27:24] = cid_q;
      end else if (sel_q == SEL_VER) begin
        acc_rdata[23:16] = 8'(NPIN - 1);
        acc_rdata[7:0]   = VER_CODE;
      end else if (tbl_hit) begin
        for (int i = 0; i < NPIN; i++) begin
          if (int'(ent) == i) begin
            if (hi_half) begin
              acc_rdata[31:24] = cfg_q[i].dest;
            end else begin
              acc_rdata[7:0]      = cfg_q[i].vec;
              acc_rdata[10:8]     = cfg_q[i].dmode;
              acc_rdata[11]       = cfg_q[i].dst_logical;
              acc_rdata[LO_DSTAT] = busy_i[i];
              acc_rdata[LO_POL]   = cfg_q[i].act_low;
              acc_rdata[LO_RPEND] = rpend_i[i];
              acc_rdata[LO_TRIG]  = cfg_q[i].lvl;
              acc_rdata[LO_MASK]  = cfg_q[i].mask;
            end
          end
        end
      end
    end
  end

  assign cfg_o = cfg_q;

  assert_select_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && acc_off == OFF_INDEX) |=> (sel_q == $past(acc_wdata[7:0])));

endmodule

// File: rtl/irq_redir_src.sv
module irq_redir_src
  import irq_redir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  redir_cfg_t cfg_i,
  input  logic       grant_i,
  input  logic       accept_i,
  input  logic       eoi_valid_i,
  input  logic [7:0] eoi_vec_i,
  output logic       req_o,
  output logic       rpend_o
);

  logic pin_q, pin_p;
  logic pend_q, pend_d;
  logic rpend_q, rpend_d;
  logic act_now, act_old, rise, taken, eoi_hit;
  logic unused_cfg;

  assign act_now = pin_q ^ cfg_i.act_low;
  assign act_old = pin_p ^ cfg_i.act_low;
  assign rise    = act_now & ~act_old;
  assign taken   = grant_i & accept_i;
  assign eoi_hit = eoi_valid_i && (eoi_vec_i == cfg_i.vec);
  assign unused_cfg = ^{cfg_i.dest, cfg_i.dmode, cfg_i.dst_logical};

  // next state
  always_comb begin
    if (cfg_i.mask || cfg_i.lvl) pend_d = 1'b0;
    else if (rise)               pend_d = 1'b1;
    else if (taken)              pend_d = 1'b0;
    else                         pend_d = pend_q;

    if (!cfg_i.lvl)              rpend_d = 1'b0;
    else if (taken)              rpend_d = 1'b1;
    else if (eoi_hit)            rpend_d = 1'b0;
    else                         rpend_d = rpend_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      pin_p   <= 1'b0;
      pend_q  <= 1'b0;
      rpend_q <= 1'b0;
    end else begin
      pin_q   <= pin_i;
      pin_p   <= pin_q;
      pend_q  <= pend_d;
      rpend_q <= rpend_d;
    end
  end

  assign req_o   = ~cfg_i.mask & (cfg_i.lvl ? (act_now & ~rpend_q) : pend_q);
  assign rpend_o = rpend_q;

  assert_edge_mode_no_rpend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.lvl |=> !rpend_q);

  assert_mask_drops_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i.mask |=> !pend_q);

  assert_level_accept_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_i && accept_i && cfg_i.lvl) |=> rpend_q);

endmodule

// File: rtl/irq_redir_arb.sv
module irq_redir_arb
  import irq_redir_pkg::*;
#(
  parameter int NPIN = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  redir_cfg_t [NPIN-1:0] cfg_i,
  input  logic [NPIN-1:0]       req_i,
  input  logic                  msg_ready,
  output logic [NPIN-1:0]       grant_o,
  output logic                  accept_o,
  output logic                  msg_valid,
  output logic [7:0]            msg_vector,
  output logic [2:0]            msg_dmode,
  output logic                  msg_logical,
  output logic                  msg_level,
  output logic [7:0]            msg_dest
);

  logic [NPIN-1:0] mask_vec;
  logic            unused_pol;

  assign grant_o   = req_i & (~req_i + NPIN'(1));
  assign msg_valid = |req_i;
  assign accept_o  = msg_valid & msg_ready;

  always_comb begin
    msg_vector  = '0;
    msg_dmode   = '0;
    msg_logical = 1'b0;
    msg_level   = 1'b0;
    msg_dest    = '0;
    unused_pol  = 1'b0;
    for (int i = 0; i < NPIN; i++) begin
      mask_vec[i] = cfg_i[i].mask;
      unused_pol  = unused_pol ^ cfg_i[i].act_low;
      if (grant_o[i]) begin
        msg_vector  = msg_vector  | cfg_i[i].vec;
        msg_dmode   = msg_dmode   | cfg_i[i].dmode;
        msg_logical = msg_logical | cfg_i[i].dst_logical;
        msg_level   = msg_level   | cfg_i[i].lvl;
        msg_dest    = msg_dest    | cfg_i[i].dest;
      end
    end
  end

  assert_no_masked_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((grant_o & mask_vec) == '0));

endmodule

// File: rtl/irq_redirect_unit.sv
module irq_redirect_unit
  import irq_redir_pkg::*;
#(
  parameter int NPIN = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      acc_off,
  input  logic            acc_we,
  input  logic [31:0]     acc_wdata,
  output logic [31:0]     acc_rdata,
  input  logic [NPIN-1:0] irq_pins,
  input  logic            eoi_valid,
  input  logic [7:0]      eoi_vector,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [7:0]      msg_vector,
  output logic [2:0]      msg_dmode,
  output logic            msg_logical,
  output logic            msg_level,
  output logic [7:0]      msg_dest
);

  redir_cfg_t [NPIN-1:0] cfg;
  logic [NPIN-1:0]       req, rpend, grant;
  logic                  accept;

  irq_redir_regs #(.NPIN(NPIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_off   (acc_off),
    .acc_we    (acc_we),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .rpend_i   (rpend),
    .busy_i    (req),
    .cfg_o     (cfg)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_src
    irq_redir_src u_src (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (irq_pins[g]),
      .cfg_i       (cfg[g]),
      .grant_i     (grant[g]),
      .accept_i    (accept),
      .eoi_valid_i (eoi_valid),
      .eoi_vec_i   (eoi_vector),
      .req_o       (req[g]),
      .rpend_o     (rpend[g])
    );
  end

  irq_redir_arb #(.NPIN(NPIN)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_i       (cfg),
    .req_i       (req),
    .msg_ready   (msg_ready),
    .grant_o     (grant),
    .accept_o    (accept),
    .msg_valid   (msg_valid),
    .msg_vector  (msg_vector),
    .msg_dmode   (msg_dmode),
    .msg_logical (msg_logical),
    .msg_level   (msg_level),
    .msg_dest    (msg_dest)
  );

endmodule

// File: tb/test_irq_redirect_unit.sv
module test_irq_redirect_unit;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    acc_off = 8'h00;
  logic          acc_we = 1'b0;
  logic [31:0]   acc_wdata = '0;
  logic [31:0]   acc_rdata;
  logic [NP-1:0] irq_pins = '0;
  logic          eoi_valid = 1'b0;
  logic [7:0]    eoi_vector = 8'h00;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic [7:0]    msg_vector;
  logic [2:0]    msg_dmode;
  logic          msg_logical;
  logic          msg_level;
  logic [7:0]    msg_dest;

  int total = 0;
  int bad = 0;
  int deliv[256];

  always #10 clk = ~clk;

  irq_redirect_unit #(.NPIN(NP)) i_irq_redirect_unit (
    .clk(clk), .rst_n(rst_n), .acc_off(acc_off), .acc_we(acc_we),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_pins(irq_pins),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dmode(msg_dmode),
    .msg_logical(msg_logical), .msg_level(msg_level), .msg_dest(msg_dest)
  );

  // behavioural reference model
  bit [7:0] m_vec[NP];
  bit [2:0] m_dm[NP];
  bit       m_dl[NP], m_al[NP], m_lv[NP], m_mk[NP];
  bit [7:0] m_dst[NP];
  bit       m_pq[NP], m_pp[NP], m_pend[NP], m_rp[NP];
  bit [7:0] m_sel;

  function automatic bit m_req(int i);
    if (m_mk[i]) return 1'b0;
    if (m_lv[i]) return (m_pq[i] ^ m_al[i]) && !m_rp[i];
    return m_pend[i];
  endfunction

  function automatic int m_win();
    for (int i = 0; i < NP; i++) if (m_req(i)) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int w;
    bit acc;
    bit np[NP];
    bit nr[NP];
    if (!rst_n) begin
      m_sel = 8'h00;
      for (int i = 0; i < NP; i++) begin
        m_vec[i] = 0; m_dm[i] = 0; m_dl[i] = 0; m_al[i] = 0; m_lv[i] = 0;
        m_mk[i] = 1; m_dst[i] = 0; m_pq[i] = 0; m_pp[i] = 0; m_pend[i] = 0; m_rp[i] = 0;
      end
    end else begin
      w = m_win();
      acc = (w >= 0) && msg_ready;
      for (int i = 0; i < NP; i++) begin
        bit a_now, a_old;
        a_now = m_pq[i] ^ m_al[i];
        a_old = m_pp[i] ^ m_al[i];
        if (m_mk[i] || m_lv[i]) np[i] = 0;
        else if (a_now && !a_old) np[i] = 1;
        else if (acc && w == i) np[i] = 0;
        else np[i] = m_pend[i];
        if (!m_lv[i]) nr[i] = 0;
        else if (acc && w == i) nr[i] = 1;
        else if (eoi_valid && eoi_vector == m_vec[i]) nr[i] = 0;
        else nr[i] = m_rp[i];
      end
      for (int i = 0; i < NP; i++) begin
        m_pend[i] = np[i]; m_rp[i] = nr[i];
        m_pp[i] = m_pq[i]; m_pq[i] = irq_pins[i];
      end
      if (acc_we && acc_off == 8'h00) m_sel = acc_wdata[7:0];
      else if (acc_we && acc_off == 8'h10 && m_sel >= 8'h10 && m_sel < 8'h10 + 2 * NP) begin
        int e;
        e = (int'(m_sel) - 16) / 2;
        if (m_sel[0]) m_dst[e] = acc_wdata[31:24];
        else begin
          m_vec[e] = acc_wdata[7:0]; m_dm[e] = acc_wdata[10:8]; m_dl[e] = acc_wdata[11];
          m_al[e] = acc_wdata[13]; m_lv[e] = acc_wdata[15]; m_mk[e] = acc_wdata[16];
        end
      end
    end
  end

  // compare model against outputs every cycle (R7, R8, R12)
  always @(negedge clk) begin : cmp
    int w;
    if (rst_n) begin
      w = m_win();
      total++;
      if (((w >= 0) != msg_valid) ||
          ((w >= 0) && (msg_vector != m_vec[w] || msg_dest != m_dst[w] ||
                        msg_dmode != m_dm[w] || msg_logical != m_dl[w] ||
                        msg_level != m_lv[w]))) begin
        bad++;
        $display("FAIL R12 cycle compare: valid=%0d vec=%h, expected valid=%0d vec=%h",
                 msg_valid, msg_vector, (w >= 0), (w >= 0) ? m_vec[w] : 8'h00);
      end
    end
  end

  always @(posedge clk) if (rst_n && msg_valid && msg_ready) deliv[msg_vector]++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] off, logic [31:0] d);
    acc_off = off; acc_wdata = d; acc_we = 1'b1;
    @(negedge clk);
    acc_we = 1'b0;
  endtask

  task automatic wreg(logic [7:0] sel, logic [31:0] d);
    wr(8'h00, {24'h0, sel});
    wr(8'h10, d);
  endtask

  task automatic rd(logic [7:0] sel, output logic [31:0] d);
    wr(8'h00, {24'h0, sel});
    acc_off = 8'h10;
    #1 d = acc_rdata;
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    for (int i = 0; i < 256; i++) deliv[i] = 0;
    tick(3);
    chk("R5 no message in reset", {31'h0, msg_valid}, 32'h0);
    rst_n = 1'b1;
    tick(1);

    rd(8'h01, d);  chk("R3 version", d, 32'h0007_0011);
    rd(8'h10, d);  chk("R5 entry0 low after reset", d, 32'h0001_0000);
    rd(8'h1F, d);  chk("R5 entry7 high after reset", d, 32'h0);
    rd(8'h00, d);  chk("R5 id after reset", d, 32'h0);
    chk("R5 idle output", {31'h0, msg_valid}, 32'h0);

    wr(8'h00, 32'hFFFF_A5C3);
    acc_off = 8'h00; #1;
    chk("R1 select readback", acc_rdata, 32'h0000_00C3);

    wreg(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d);  chk("R2 id bits", d, 32'h0F00_0000);
    wreg(8'h01, 32'h0);
    rd(8'h01, d);  chk("R3 version read-only", d, 32'h0007_0011);

    wreg(8'h14, 32'h0001_7FFF);
    rd(8'h14, d);  chk("R4 low word fields", d, 32'h0001_2FFF);
    wreg(8'h15, 32'hFFFF_FFFF);
    rd(8'h15, d);  chk("R4 high word dest", d, 32'hFF00_0000);
    rd(8'h20, d);  chk("R4 beyond table", d, 32'h0);
    wreg(8'h14, 32'h0001_0000);
    wreg(8'h15, 32'h0);

    // R7 edge entry 0
    wreg(8'h10, 32'h0000_0130);
    wreg(8'h11, 32'h0500_0000);
    irq_pins[0] = 1'b1;
    tick(1);
    chk("R7 not yet after one edge", {31'h0, msg_valid}, 32'h0);
    tick(1);
    chk("R7 valid after two edges", {31'h0, msg_valid}, 32'h1);
    chk("R12 vector", {24'h0, msg_vector}, 32'h30);
    chk("R12 dest", {24'h0, msg_dest}, 32'h05);
    chk("R12 dmode", {29'h0, msg_dmode}, 32'h1);
    tick(6);
    chk("R7 one message per edge", deliv[8'h30], 1);
    irq_pins[0] = 1'b0;
    tick(3);

    // R6 active-low edge entry 1
    wreg(8'h12, 32'h0000_2031);
    irq_pins[1] = 1'b1;
    tick(4);
    chk("R6 rising pin ignored when active low", deliv[8'h31], 0);
    irq_pins[1] = 1'b0;
    tick(4);
    chk("R6 falling pin fires when active low", deliv[8'h31], 1);

    // R8 / R9 level entry 3
    wreg(8'h16, 32'h0000_8050);
    irq_pins[3] = 1'b1;
    tick(5);
    chk("R8 level delivers once", deliv[8'h50], 1);
    rd(8'h16, d);  chk("R8 remote pending set", d, 32'h0000_C050);
    eoi(8'h51);
    tick(3);
    chk("R9 other vector no effect", deliv[8'h50], 1);
    rd(8'h16, d);  chk("R9 remote pending kept", d, 32'h0000_C050);
    eoi(8'h50);
    tick(3);
    chk("R9 matching eoi re-arms", deliv[8'h50], 2);
    irq_pins[3] = 1'b0;
    eoi(8'h50);
    tick(2);
    rd(8'h16, d);  chk("R9 remote pending cleared", d, 32'h0000_8050);

    // R10 stuck recovery
    irq_pins[3] = 1'b1;
    tick(3);
    chk("R10 setup delivery", deliv[8'h50], 3);
    irq_pins[3] = 1'b0;
    tick(1);
    wreg(8'h16, 32'h0001_0050);
    wreg(8'h16, 32'h0000_8050);
    rd(8'h16, d);  chk("R10 remote pending cleared by edge rewrite", d, 32'h0000_8050);
    irq_pins[3] = 1'b1;
    tick(3);
    chk("R10 delivery resumes", deliv[8'h50], 4);
    irq_pins[3] = 1'b0;
    eoi(8'h50);
    tick(1);

    // R11 mask
    wreg(8'h18, 32'h0001_0060);
    irq_pins[4] = 1'b1;
    tick(3);
    irq_pins[4] = 1'b0;
    tick(3);
    chk("R11 masked edge lost", deliv[8'h60], 0);
    msg_ready = 1'b0;
    wreg(8'h18, 32'h0000_0060);
    irq_pins[4] = 1'b1;
    tick(3);
    chk("R11 latched before mask", {24'h0, msg_vector}, 32'h60);
    wreg(8'h18, 32'h0001_0060);
    tick(1);
    chk("R11 mask drops latched edge", {31'h0, msg_valid}, 32'h0);
    irq_pins[4] = 1'b0;
    msg_ready = 1'b1;
    wreg(8'h18, 32'h0000_0060);
    tick(4);
    chk("R11 nothing after unmask", deliv[8'h60], 0);

    // R12 arbitration and hold
    msg_ready = 1'b0;
    wreg(8'h14, 32'h0000_0A42);
    wreg(8'h15, 32'h7700_0000);
    irq_pins[0] = 1'b1;
    irq_pins[2] = 1'b1;
    tick(3);
    chk("R12 lowest index wins", {24'h0, msg_vector}, 32'h30);
    rd(8'h14, d);  chk("R12 delivery status", d, 32'h0000_1A42);
    chk("R12 held while not ready", {31'h0, msg_valid}, 32'h1);
    msg_ready = 1'b1;
    tick(1);
    chk("R12 next vector", {24'h0, msg_vector}, 32'h42);
    chk("R12 next dmode", {29'h0, msg_dmode}, 32'h2);
    chk("R12 next logical", {31'h0, msg_logical}, 32'h1);
    chk("R12 next dest", {24'h0, msg_dest}, 32'h77);
    tick(2);
    chk("R12 entry0 count", deliv[8'h30], 2);
    chk("R12 entry2 count", deliv[8'h42], 1);
    irq_pins[0] = 1'b0;
    irq_pins[2] = 1'b0;
    tick(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule